// File: doc/BRIEF.md
# DMA Channel Interrupt Controller

This block is the interrupt logic for a four-channel DMA engine. The four sources are receive A, transmit A, receive B and transmit B. Each source has an interrupt-pending (IP) flag and an interrupt-under-service (IUS) flag. The DMA engine sets IP through a hardware strobe per channel. Software sets or clears IP and IUS through a write-only command register, where a 3-bit opcode acts on a 4-bit source mask.

The sources are arbitrated in a fixed order. The block raises a request when the winning enabled pending source is not held off by an IUS flag at its own level or above. During an acknowledge cycle the block returns a vector. That vector is the programmed vector byte, or the same byte with bits 3:1 replaced by a code that names the winner. The block can also be told to leave the bus undriven. The winner's IUS flag is set at the acknowledge edge.

Top module: `dmairq_ctrl`

## Requirements
- R1: After reset the control register, the vector register and every IP and IUS flag are zero. irq_o is low and vec_oe_o is low.
- R2: Address 0x01 holds the control register: bit 5 is no-vector, bit 4 is vector-with-status and bits 3:0 are source enables. Bits 7:6 read as zero. Address 0x02 holds a readable and writable 8-bit vector. A read of 0x03 returns {IUS[3:0], IP[3:0]}. Any other address reads zero.
- R3: In every 4-bit source mask (enables, command mask, status nibbles, hw_ip_set_i), bit 3 is receive A, bit 2 is transmit A, bit 1 is receive B and bit 0 is transmit B. A write to 0x03 uses bits 7:5 as the opcode: 000 no-op, 001 clear IP, 010 clear IUS, 011 clear both, 100 no-op, 101 set IP, 110 set IUS, 111 set both. The opcode applies to the sources selected by bits 3:0. Bit 4 is ignored.
- R4: A high bit of hw_ip_set_i sets that source's IP. When this coincides with a command clearing the same IP, the IP is still set.
- R5: The winner is the first source, in the order receive A, receive B, transmit A, transmit B, whose IP and enable are both set. irq_o is high exactly when a winner exists and no source at or above the winner's rank has IUS set. A disabled source keeps its IP but never wins.
- R6: At a clock edge with iack_i and irq_o both high, the winner's IUS is set and no other flag changes. With irq_o low, an acknowledge changes no flag.
- R7: vec_oe_o equals iack_i while no-vector is clear, and is low while no-vector is set. vec_o is zero whenever vec_oe_o is low.
- R8: With vector-with-status clear, vec_o is the vector register. With it set, vec_o bits 3:1 are 000 when there is no winner, and 100, 101, 110 or 111 when the winner is receive A, receive B, transmit A or transmit B. The other bits of vec_o come from the vector register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational, zero when rd_i is low |
| hw_ip_set_i | input | 4 | Per-source IP set strobes from the DMA engine |
| irq_o | output | 1 | Interrupt request |
| iack_i | input | 1 | Interrupt acknowledge, one cycle per acknowledge |
| vec_o | output | 8 | Vector driven during acknowledge |
| vec_oe_o | output | 1 | Vector output enable |

## Verification
The hardest condition to reach from the ports is the interaction of pending, enabled and in-service flags across the four priority ranks, because IUS only rises through an acknowledge or a command. The bench uses the command register to force every combination of IP and IUS flags under every enable mask. For each combination it checks the request, the status code in the vector and the IUS update caused by an acknowledge. Directed cases cover a hardware set colliding with a command clear, the ignored opcodes, and the no-vector mode.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int N_SRC  = 4;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int CODE_W = 3;

  typedef enum logic [2:0] {
    CMD_NULL     = 3'b000,
    CMD_CLR_IP   = 3'b001,
    CMD_CLR_IUS  = 3'b010,
    CMD_CLR_BOTH = 3'b011,
    CMD_RSVD     = 3'b100,
    CMD_SET_IP   = 3'b101,
    CMD_SET_IUS  = 3'b110,
    CMD_SET_BOTH = 3'b111
  } cmd_e;

  typedef struct packed {
    logic             no_vec;
    logic             with_status;
    logic [N_SRC-1:0] en;
  } ctrl_t;

  // mask order: 3 rx_a, 2 tx_a, 1 rx_b, 0 tx_b; rank order: rx_a, rx_b, tx_a, tx_b
  function automatic logic [N_SRC-1:0] mask_to_rank(input logic [N_SRC-1:0] m);
    return {m[0], m[2], m[1], m[3]};
  endfunction

  function automatic logic [N_SRC-1:0] rank_to_mask(input logic [N_SRC-1:0] r);
    return {r[0], r[2], r[1], r[3]};
  endfunction
endpackage

// File: rtl/dmairq_regs.sv
module dmairq_regs
  import dmairq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 5'h01,
  parameter logic [ADDR_W-1:0] VEC_ADDR  = 5'h02,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 5'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  ip_i,
  input  logic [N_SRC-1:0]  ius_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] vec_reg_o,
  output logic [N_SRC-1:0]  set_ip_o,
  output logic [N_SRC-1:0]  clr_ip_o,
  output logic [N_SRC-1:0]  set_ius_o,
  output logic [N_SRC-1:0]  clr_ius_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] vec_q;
  logic              cmd_we;
  cmd_e              cmd;
  logic [N_SRC-1:0]  cmd_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      vec_q  <= '0;
    end else if (wr_i) begin
      if (addr_i == CTRL_ADDR) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (addr_i == VEC_ADDR)  vec_q  <= wdata_i;
    end
  end

  assign cmd_we   = wr_i && (addr_i == CMD_ADDR);
  assign cmd      = cmd_e'(wdata_i[DATA_W-1 -: 3]);
  assign cmd_mask = wdata_i[N_SRC-1:0];

  // bit 2 of opcode: set/clear; bit 0: IP; bit 1: IUS; reserved 100 touches neither
  always_comb begin
    set_ip_o  = '0;
    clr_ip_o  = '0;
    set_ius_o = '0;
    clr_ius_o = '0;
    if (cmd_we) begin
      if (cmd[2]) begin
        if (cmd[0]) set_ip_o  = cmd_mask;
        if (cmd[1]) set_ius_o = cmd_mask;
      end else begin
        if (cmd[0]) clr_ip_o  = cmd_mask;
        if (cmd[1]) clr_ius_o = cmd_mask;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        CTRL_ADDR: rdata_o = DATA_W'(ctrl_q);
        VEC_ADDR:  rdata_o = vec_q;
        CMD_ADDR:  rdata_o = {ius_i, ip_i};
        default:   rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o    = ctrl_q;
  assign vec_reg_o = vec_q;

  p_set_clr_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_ip_o & clr_ip_o) == '0) && ((set_ius_o & clr_ius_o) == '0));
endmodule

// File: rtl/dmairq_state.sv
module dmairq_state
  import dmairq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] hw_set_i,
  input  logic [N_SRC-1:0] set_ip_i,
  input  logic [N_SRC-1:0] clr_ip_i,
  input  logic [N_SRC-1:0] set_ius_i,
  input  logic [N_SRC-1:0] clr_ius_i,
  input  logic [N_SRC-1:0] ack_set_i,
  output logic [N_SRC-1:0] ip_o,
  output logic [N_SRC-1:0] ius_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic ip_q, ius_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ip_q  <= 1'b0;
        ius_q <= 1'b0;
      end else begin
        // any set beats a clear in the same cycle
        ip_q  <= (ip_q & ~clr_ip_i[i]) | set_ip_i[i] | hw_set_i[i];
        ius_q <= (ius_q & ~clr_ius_i[i]) | set_ius_i[i] | ack_set_i[i];
      end
    end
    assign ip_o[i]  = ip_q;
    assign ius_o[i] = ius_q;
  end

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hw_set_i | set_ip_i | clr_ip_i | set_ius_i | clr_ius_i | ack_set_i) == '0)
    |=> ($stable(ip_o) && $stable(ius_o)));

  p_hw_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set_i != '0) |=> ((ip_o & $past(hw_set_i)) == $past(hw_set_i)));
endmodule

// File: rtl/dmairq_prio.sv
module dmairq_prio
  import dmairq_pkg::*;
(
  input  logic [N_SRC-1:0]  ip_i,
  input  logic [N_SRC-1:0]  ius_i,
  input  logic [N_SRC-1:0]  en_i,
  output logic              irq_o,
  output logic [N_SRC-1:0]  win_mask_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int RANK_W = $clog2(N_SRC);

  logic [N_SRC-1:0]  pend_r, ius_r, win_r;
  logic              found, blocked;
  logic [RANK_W-1:0] rank;

  assign pend_r = mask_to_rank(ip_i & en_i);
  assign ius_r  = mask_to_rank(ius_i);

  always_comb begin
    found   = 1'b0;
    blocked = 1'b0;
    rank    = '0;
    win_r   = '0;
    for (int k = 0; k < N_SRC; k++) begin
      if (!found) begin
        if (ius_r[k]) blocked = 1'b1;
        if (pend_r[k]) begin
          found    = 1'b1;
          rank     = RANK_W'(k);
          win_r[k] = 1'b1;
        end
      end
    end
  end

  assign irq_o      = found && !blocked;
  assign win_mask_o = rank_to_mask(win_r);
  assign code_o     = found ? {1'b1, rank} : '0;
endmodule

// File: rtl/dmairq_ctrl.sv
module dmairq_ctrl
  import dmairq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  hw_ip_set_i,
  output logic              irq_o,
  input  logic              iack_i,
  output logic [DATA_W-1:0] vec_o,
  output logic              vec_oe_o
);
  ctrl_t              ctrl;
  logic [DATA_W-1:0]  vec_reg, vec_val;
  logic [N_SRC-1:0]   set_ip, clr_ip, set_ius, clr_ius, ack_set;
  logic [N_SRC-1:0]   ip_q, ius_q, win_mask;
  logic [CODE_W-1:0]  code;
  logic               irq;

  dmairq_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .ip_i      (ip_q),
    .ius_i     (ius_q),
    .ctrl_o    (ctrl),
    .vec_reg_o (vec_reg),
    .set_ip_o  (set_ip),
    .clr_ip_o  (clr_ip),
    .set_ius_o (set_ius),
    .clr_ius_o (clr_ius)
  );

  dmairq_state u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_set_i  (hw_ip_set_i),
    .set_ip_i  (set_ip),
    .clr_ip_i  (clr_ip),
    .set_ius_i (set_ius),
    .clr_ius_i (clr_ius),
    .ack_set_i (ack_set),
    .ip_o      (ip_q),
    .ius_o     (ius_q)
  );

  dmairq_prio u_prio (
    .ip_i       (ip_q),
    .ius_i      (ius_q),
    .en_i       (ctrl.en),
    .irq_o      (irq),
    .win_mask_o (win_mask),
    .code_o     (code)
  );

  assign ack_set  = (iack_i && irq) ? win_mask : '0;
  assign vec_val  = ctrl.with_status ? {vec_reg[DATA_W-1:4], code, vec_reg[0]} : vec_reg;
  assign vec_oe_o = iack_i && !ctrl.no_vec;
  assign vec_o    = vec_oe_o ? vec_val : '0;
  assign irq_o    = irq;

  p_irq_needs_ip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((ip_q & ctrl.en) != '0));

  p_ack_sets_ius_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iack_i && irq_o) |=> ($countones(ius_q & ~$past(ius_q)) <= 1) && (ius_q != '0));

  p_code_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_oe_o && ctrl.with_status) |-> (vec_o[3] || (vec_o[3:1] == 3'b000)));

  p_quiet_bus_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iack_i |-> (!vec_oe_o && (vec_o == '0)));
endmodule

// File: tb/sim_dmairq_ctrl.sv
module sim_dmairq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0, iack = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, vec;
  logic [3:0] hw = '0;
  logic       irq, vec_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dmairq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .hw_ip_set_i(hw), .irq_o(irq),
    .iack_i(iack), .vec_o(vec), .vec_oe_o(vec_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  // rank k -> mask bit: rx_a 3, rx_b 1, tx_a 2, tx_b 0
  function automatic int rbit(input int k);
    case (k)
      0: return 3;
      1: return 1;
      2: return 2;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_reg(5'h01, d); check("R1 ctrl", d, 0);
    rd_reg(5'h02, d); check("R1 vector", d, 0);
    rd_reg(5'h03, d); check("R1 status", d, 0);
    check("R1 irq", irq, 0);
    check("R1 oe", vec_oe, 0);

    // R2 register map
    wr_reg(5'h01, 8'hFF); rd_reg(5'h01, d); check("R2 ctrl 7:6 zero", d, 8'h3F);
    wr_reg(5'h02, 8'h5A); rd_reg(5'h02, d); check("R2 vector rw", d, 8'h5A);
    rd_reg(5'h07, d); check("R2 unmapped", d, 0);
    wr_reg(5'h01, 8'h00);

    // R3 command decode
    wr_reg(5'h03, 8'h0F); rd_reg(5'h03, d); check("R3 null", d, 0);
    wr_reg(5'h03, 8'h8F); rd_reg(5'h03, d); check("R3 reserved", d, 0);
    wr_reg(5'h03, 8'hBF); rd_reg(5'h03, d); check("R3 set ip bit4 ignored", d, 8'h0F);
    wr_reg(5'h03, 8'h2F); rd_reg(5'h03, d); check("R3 clr ip", d, 0);
    wr_reg(5'h03, 8'hC5); rd_reg(5'h03, d); check("R3 set ius", d, 8'h50);
    wr_reg(5'h03, 8'hE3); rd_reg(5'h03, d); check("R3 set both", d, 8'h73);
    wr_reg(5'h03, 8'h44); rd_reg(5'h03, d); check("R3 clr ius", d, 8'h33);
    wr_reg(5'h03, 8'h6F); rd_reg(5'h03, d); check("R3 clr both", d, 0);

    // R4 hardware set beats command clear
    wr_reg(5'h03, 8'hAF);
    @(negedge clk);
    addr = 5'h03; wdata = 8'h2F; wr = 1'b1; hw = 4'b0100;
    @(negedge clk);
    wr = 1'b0; hw = '0;
    rd_reg(5'h03, d); check("R4 hw wins", d, 8'h04);
    @(negedge clk); hw = 4'b0001;
    @(negedge clk); hw = '0;
    rd_reg(5'h03, d); check("R4 hw set", d, 8'h05);

    // R6 acknowledge with irq low changes nothing
    wr_reg(5'h01, 8'h00);
    check("R6 irq low when disabled", irq, 0);
    @(negedge clk); iack = 1'b1;
    @(negedge clk); iack = 1'b0;
    rd_reg(5'h03, d); check("R6 no ius on idle ack", d, 8'h05);

    // R7 no-vector mode; acknowledge still marks service
    wr_reg(5'h02, 8'hA5);
    wr_reg(5'h01, 8'h2F);
    check("R7 irq", irq, 1);
    @(negedge clk); iack = 1'b1;
    #1 check("R7 oe low", vec_oe, 0); check("R7 vec zero", vec, 0);
    @(negedge clk); iack = 1'b0;
    rd_reg(5'h03, d); check("R6 ius tx_a", d, 8'h45);

    // R8 plain vector
    wr_reg(5'h03, 8'h6F); wr_reg(5'h03, 8'hA8); wr_reg(5'h01, 8'h0F);
    @(negedge clk); iack = 1'b1;
    #1 check("R7 oe high", vec_oe, 1); check("R8 plain vector", vec, 8'hA5);
    @(negedge clk); iack = 1'b0;

    // R5 R6 R8 sweep over enables, IP and IUS
    for (int en = 0; en < 16; en++) begin
      for (int ip = 0; ip < 16; ip++) begin
        for (int us = 0; us < 16; us++) begin
          int win, code, exp_irq, exp_ius;
          bit blk;
          win = -1; blk = 1'b0;
          for (int k = 0; k < 4; k++) begin
            if (win < 0) begin
              if (us[rbit(k)]) blk = 1'b1;
              if (ip[rbit(k)] && en[rbit(k)]) win = k;
            end
          end
          exp_irq = (win >= 0 && !blk) ? 1 : 0;
          code    = (win >= 0) ? 4 + win : 0;
          exp_ius = us | (exp_irq ? (1 << rbit(win)) : 0);
          wr_reg(5'h01, 8'h10 | 8'(en));
          wr_reg(5'h03, 8'h6F);
          wr_reg(5'h03, 8'hA0 | 8'(ip));
          wr_reg(5'h03, 8'hC0 | 8'(us));
          check("R5 irq", irq, exp_irq);
          iack = 1'b1;
          #1 check("R8 status vector", vec, 8'hA1 | (code << 1));
          @(negedge clk); iack = 1'b0;
          rd_reg(5'h03, d);
          check("R6 ack update", d, (exp_ius << 4) | ip);
        end
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule